// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is the bus-facing end of a small byte-addressed memory that sits on a two-wire I2C bus as a target. It oversamples the clock and data lines with the system clock, finds START and STOP conditions, and checks the 7-bit device address that follows each START. It then carries out either a write or a read, and it acknowledges or returns data by enabling an open-drain pull-down on the data line.

In a write, the first byte after the address loads an internal 8-bit pointer. Each later byte is handed to the memory as a one-cycle strobe that carries the pointer and the byte, and the pointer then advances. In a read, the block fetches the byte at the pointer through a request/return pair and shifts it out MSB first. It keeps going for as long as the master acknowledges. A busy input makes the block go silent at every acknowledge decision, even when it sees its own address.

Top module: `i2c_mem_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA, and it gives no acknowledge to bytes clocked before the next START. At reset `sda_oe`, `wr_en` and `rd_req` are low.
- R2: The first byte after a START holds the 7-bit device address, MSB first, in bits 7..1 and the R/W flag in bit 0. On a match with `DEV_ADDR` (default 7'h50) the block holds `sda_oe` high for the whole ninth SCL clock. On a mismatch it never drives SDA until the next START.
- R3: With R/W = 0, the first byte after the address is acknowledged, loads the pointer and produces no write strobe.
- R4: Each later write byte is acknowledged and produces one single-cycle `wr_en` pulse, with `wr_addr` set to the pointer and `wr_data` set to the byte. The pointer then increments modulo 256.
- R5: With R/W = 1 the block pulses `rd_req` with `rd_addr` equal to the pointer. It takes `rd_data` on the second clock edge after the pulse and sends that byte MSB first, with `sda_oe` high for 0 bits. It releases SDA for the ninth clock.
- R6: After each byte sent, the pointer increments modulo 256. If the master acknowledged, the next byte is fetched from the new pointer and sent.
- R7: If the master does not acknowledge, the block stops driving SDA and ignores all further clocks until a STOP or START.
- R8: While `busy` is high at an acknowledge decision, the block does not acknowledge, even its own address. It issues no `wr_en` or `rd_req` and ignores the bus until the next START.
- R9: A repeated START in the middle of a transfer restarts address matching. The pointer is kept, so a write of only a word address followed by a repeated START and a read gives a random-address read.
- R10: `sda_oe` only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | input | 1 | Suppress every response |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 8 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_req` |

## Verification
Address matching is swept over all 128 device addresses. A second byte after each probe shows that non-matching targets stay silent instead of merely missing one acknowledge. A 16-byte write burst starting at 0xF8 and a 20-byte read burst starting at 0xF6 both cross the pointer wrap. Byte values are computed arithmetically, so any error in pointer stepping, bit order or read prefetch shows up in the returned data. Separate patterns cover a master NACK followed by extra clocks, `busy` raised before the address and in the middle of a write, and a repeated START both between a word address and a read and in the middle of a write. These separate the rules for ignoring the bus from the rules for restarting on a new START.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       busy,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_WAIT} st_t;
  typedef enum logic [1:0] {B_DEV, B_WORD, B_DATA} kind_t;

  logic [SYNC-1:0] scl_p, sda_p;
  logic scl_q, sda_q;
  st_t st;
  kind_t kind;
  logic [3:0] cnt;
  logic [7:0] sr, tx, ptr;
  logic rw, mack, ld;

  wire scl_s = scl_p[SYNC-1];
  wire sda_s = sda_p[SYNC-1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire ack_ok    = !busy && (kind != B_DEV || sr[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC-2:0], scl_i};
      sda_p <= {sda_p[SYNC-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= B_DEV;
      cnt <= '0;
      sr <= '0;
      tx <= '0;
      ptr <= '0;
      rw <= 1'b0;
      mack <= 1'b0;
      ld <= 1'b0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_req <= 1'b0;
      rd_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_req <= 1'b0;
      ld <= rd_req;
      if (ld) tx <= rd_data;
      if (start_det) begin
        st <= S_RX;
        kind <= B_DEV;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sr <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (!ack_ok) st <= S_WAIT;
              else begin
                st <= S_RXACK;
                sda_oe <= 1'b1;
                case (kind)
                  B_DEV: begin
                    rw <= sr[0];
                    if (sr[0]) begin
                      rd_req <= 1'b1;
                      rd_addr <= ptr;
                    end
                  end
                  B_WORD: ptr <= sr;
                  default: begin
                    wr_en <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= sr;
                    ptr <= ptr + 8'd1;
                  end
                endcase
              end
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == B_DEV && rw) begin
                st <= S_TX;
                sda_oe <= ~tx[7];
              end else begin
                st <= S_RX;
                sda_oe <= 1'b0;
                kind <= (kind == B_DEV) ? B_WORD : B_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st <= S_TXACK;
              end else begin
                cnt <= cnt + 4'd1;
                tx <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda_s && !busy;
              ptr <= ptr + 8'd1;
              if (~sda_s && !busy) begin
                rd_req <= 1'b1;
                rd_addr <= ptr + 8'd1;
              end
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                st <= S_TX;
                sda_oe <= ~tx[7];
              end else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $past(stop_det) |-> !sda_oe); // R1
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st == S_RXACK) |-> sda_oe); // R2
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R5
  AST_QUIET_STATES: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE || st == S_WAIT || st == S_TXACK) |-> !sda_oe); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !$past(busy)); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s); // R10

endmodule

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_oe, wr_en, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [256];
  logic [7:0] em [256];
  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, viol = 0;
  logic [7:0] last_wa, last_wd;
  logic prev_oe = 1'b0;
  bit done = 1'b0;
  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_mem_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_addr] <= wr_data;
        wr_cnt <= wr_cnt + 1;
        last_wa <= wr_addr;
        last_wd <= wr_data;
      end
      if (rd_req) begin
        rd_data <= mem[rd_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    prev_oe <= sda_oe;
    if (rst_n && sda_oe != prev_oe && m_scl) viol <= viol + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hq(input int n = 10);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    m_sda = b; hq();
    m_scl = 1'b1; hq(5);
    r = sda_line; hq(5);
    m_scl = 1'b0; hq();
  endtask

  task automatic do_start;
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic do_stop;
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i], r);
    send_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, r);
      b[i] = r;
    end
    send_bit(!mack, r);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int w0, r0;
    for (int i = 0; i < 256; i++) em[i] = pat(i);
    hq(4);
    rst_n = 1'b1;
    hq(4);
    check("R1 reset oe", sda_oe, 0);
    check("R1 reset wr_en", wr_en, 0);
    check("R1 reset rd_req", rd_req, 0);

    for (int ad = 0; ad < 128; ad++) begin
      do_start();
      wbyte({7'(ad), 1'b0}, a);
      check("R2 address match", a, ad == 'h50);
      wbyte(8'h00, a);
      check("R2 follow-on byte", a, ad == 'h50);
      do_stop();
      check("R1 released after stop", sda_oe, 0);
    end
    check("R3 no write on word address", wr_cnt, 0);

    do_start(); do_stop();
    wbyte(8'hA0, a);
    check("R1 no ack without start", a, 0);

    do_start();
    wbyte(8'hA0, a); check("R2 write addr ack", a, 1);
    wbyte(8'hF8, a); check("R3 word ack", a, 1);
    for (int k = 0; k < 16; k++) begin
      w0 = wr_cnt;
      d = 8'((k * 13 + 5) & 255);
      wbyte(d, a);
      em[(248 + k) & 255] = d;
      check("R4 data ack", a, 1);
      check("R4 one strobe", wr_cnt - w0, 1);
      check("R4 wr_addr", last_wa, (248 + k) & 255);
      check("R4 wr_data", last_wd, d);
    end
    do_stop();

    r0 = rd_cnt;
    do_start();
    wbyte(8'hA0, a); wbyte(8'hF6, a);
    do_start();
    wbyte(8'hA1, a); check("R9 restart read addr ack", a, 1);
    for (int k = 0; k < 20; k++) begin
      rbyte(k != 19, d);
      check("R5 R6 read byte", d, em[(246 + k) & 255]);
    end
    do_stop();
    check("R6 one fetch per byte", rd_cnt - r0, 20);

    r0 = rd_cnt;
    do_start();
    wbyte(8'hA1, a); check("R5 read addr ack", a, 1);
    rbyte(1'b0, d);
    check("R6 read continues at pointer", d, em[(246 + 20) & 255]);
    rbyte(1'b1, d);
    check("R7 no drive after nack", d, 8'hFF);
    check("R7 no fetch after nack", rd_cnt - r0, 1);
    do_stop();

    w0 = wr_cnt; r0 = rd_cnt;
    busy = 1'b1;
    do_start(); wbyte(8'hA0, a); check("R8 busy write addr", a, 0); do_stop();
    do_start(); wbyte(8'hA1, a); check("R8 busy read addr", a, 0); do_stop();
    busy = 1'b0;
    check("R8 no fetch while busy", rd_cnt - r0, 0);
    do_start();
    wbyte(8'hA0, a); wbyte(8'h10, a);
    busy = 1'b1;
    wbyte(8'h55, a); check("R8 busy data nack", a, 0);
    busy = 1'b0;
    wbyte(8'h66, a); check("R8 ignored after busy", a, 0);
    do_stop();
    check("R8 no write strobe", wr_cnt - w0, 0);

    do_start();
    wbyte(8'hA0, a); wbyte(8'h20, a); wbyte(8'h11, a);
    do_start();
    wbyte(8'hA0, a); check("R9 restart mid write", a, 1);
    wbyte(8'h30, a); wbyte(8'h22, a);
    do_stop();
    em[8'h20] = 8'h11; em[8'h30] = 8'h22;
    foreach (em[i]) check("R4 R9 memory image", mem[i], em[i]);

    do_start(); wbyte(8'hA0, a); wbyte(8'h10, a);
    do_start(); wbyte(8'hA1, a); rbyte(1'b0, d); do_stop();
    check("R8 busy byte unchanged", d, em[8'h10]);

    check("R10 oe changes with SCL low", viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule